// File: doc/BRIEF.md
# I2C EEPROM Device Address Decoder

This block is the first stage of an I2C serial EEPROM slave. It watches the bus for a START, shifts in the eight-bit device address word most significant bit first, and decides whether the word is addressed to this device. The word carries three fields. The upper four bits are a control code, the next three are chip-select bits, and the last bit gives the direction.

Three control codes are recognised, and each one selects a different region:

- the main memory array;
- the software write-protect register;
- a read-only identity block that holds the serial number and the EUI address.

When the word matches, the block pulls SDA low through an open-drain enable during the ninth clock. It also reports the region, the direction and a pointer-set-only flag to the byte-handling logic that follows. When the word does not match, the block releases the bus and waits for the next START.

The write-protect code is refused once the write-protect register has been locked. A write-direction word to the identity block is acknowledged only as a pointer-set dummy write, and it is flagged as such.

Top module: `eeprom_addr_decode`

## Requirements
- R1: After a START (SDA falling while SCL is high), the block samples eight bits on the rising edges of SCL, most significant bit first. A word whose control code is 4'b1010 and whose chip-select bits match is acknowledged in either direction, with region code 2'b00 (main array).
- R2: Control code 4'b0110 with the direction bit 0 (write) is acknowledged with region code 2'b01 (write-protect register) while wp_locked is low. With the direction bit 1 (read) it is not acknowledged.
- R3: While wp_locked is high, a word with control code 4'b0110 is not acknowledged, and hit stays low.
- R4: Control code 4'b1011 is acknowledged with region code 2'b10 (identity block). For a read, ptr_only is 0. For a write, ptr_only is 1 because only the address pointer may be loaded.
- R5: Bits [3:1] of the word (A2, A1, A0) must equal strap_sel[2:0]. On a mismatch there is no acknowledge and no hit.
- R6: Any control code other than 4'b1010, 4'b0110 and 4'b1011 is not acknowledged.
- R7: On a match, sda_pull rises after the falling edge of the eighth SCL clock, together with a single-cycle hit pulse. It falls after the falling edge of the ninth SCL clock.
- R8: A START in the middle of a word discards the partial word and starts counting afresh. A STOP (SDA rising while SCL is high) discards the partial word, and bits clocked after it without a new START are ignored.
- R9: Out of reset, sda_pull and hit are 0.
- R10: The rd output equals bit 0 of the matched word, where 1 means read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| strap_sel | input | 3 | Chip-select straps, compared against A2..A0 |
| wp_locked | input | 1 | The write-protect register has been programmed |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low |
| hit | output | 1 | One-cycle pulse when an address word matches |
| region | output | 2 | Selected region: 00 main, 01 write-protect, 10 identity |
| rd | output | 1 | Direction of the matched word, 1 = read |
| ptr_only | output | 1 | Matched identity-block write; only the pointer may be set |

## Verification
The bench covers each control code in both directions, including the write-protect code before and after locking. A decoder that ignores the lock would acknowledge the locked write. A decoder that missed the dummy-write rule would report an identity write with ptr_only low.

The bench sends words whose chip-select bits differ from the straps in a single position. A decoder that compares too few bits would acknowledge them.

The bench aborts words part-way through, once with a repeated START and once with a STOP followed by bare clocks. A bit counter that is not cleared would misalign the next word or acknowledge stray bits.

The release of SDA after the ninth clock is checked explicitly, so an acknowledge that is held too long is caught.

// File: rtl/eeprom_addr_decode.sv
module eeprom_addr_decode #(
  parameter int SYNC_STAGES = 2,
  parameter logic [3:0] CODE_MAIN = 4'b1010,
  parameter logic [3:0] CODE_WP   = 4'b0110,
  parameter logic [3:0] CODE_ID   = 4'b1011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_sel,
  input  logic       wp_locked,
  output logic       sda_pull,
  output logic       hit,
  output logic [1:0] region,
  output logic       rd,
  output logic       ptr_only
);
  localparam int WORD_W = 8;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_ACK} state_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;
  state_t state;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] word;

  wire scl_s  = scl_sync[SYNC_STAGES-1];
  wire sda_s  = sda_sync[SYNC_STAGES-1];
  wire scl_up = scl_s & ~scl_d;
  wire scl_dn = ~scl_s & scl_d;
  wire start  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop   = scl_s & scl_d & ~sda_d & sda_s;

  wire [3:0] code   = word[7:4];
  wire       sel_ok = (word[3:1] == strap_sel);
  wire       dir    = word[0];

  logic       ok;
  logic [1:0] reg_n;
  always_comb begin
    ok    = 1'b0;
    reg_n = 2'b00;
    case (code)
      CODE_MAIN: begin ok = 1'b1;               reg_n = 2'b00; end
      CODE_WP:   begin ok = ~dir & ~wp_locked;  reg_n = 2'b01; end
      CODE_ID:   begin ok = 1'b1;               reg_n = 2'b10; end
      default:   begin ok = 1'b0;               reg_n = 2'b00; end
    endcase
  end
  wire match = ok & sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      word     <= '0;
      sda_pull <= 1'b0;
      hit      <= 1'b0;
      region   <= 2'b00;
      rd       <= 1'b0;
      ptr_only <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (start) begin
        state    <= ST_SHIFT;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (scl_up && cnt < CNT_W'(WORD_W)) begin
              word <= {word[WORD_W-2:0], sda_s};
              cnt  <= cnt + 1'b1;
            end else if (scl_dn && cnt == CNT_W'(WORD_W)) begin
              cnt <= '0;
              if (match) begin
                state    <= ST_ACK;
                sda_pull <= 1'b1;
                hit      <= 1'b1;
                region   <= reg_n;
                rd       <= dir;
                ptr_only <= (code == CODE_ID) & ~dir;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_dn) begin
              sda_pull <= 1'b0;
              state    <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/addr_decode_checker.sv
module addr_decode_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_locked,
  input logic       sda_pull,
  input logic       hit,
  input logic [1:0] region,
  input logic       rd,
  input logic       ptr_only
);
  assert_hit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

  assert_ack_with_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> hit);

  assert_hit_drives_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> sda_pull);

  assert_wp_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && region == 2'b01) |-> !$past(wp_locked));

  assert_wp_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && region == 2'b01) |-> !rd);

  assert_ptr_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ptr_only) |-> (region == 2'b10 && !rd));
endmodule

bind eeprom_addr_decode addr_decode_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wp_locked(wp_locked), .sda_pull(sda_pull),
  .hit(hit), .region(region), .rd(rd), .ptr_only(ptr_only)
);

// File: tb/test_eeprom_addr_decode.sv
module test_eeprom_addr_decode;
  localparam int HP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap_sel = 3'b101;
  logic wp_locked = 1'b0;
  logic sda_pull, hit, rd, ptr_only;
  logic [1:0] region;
  wire  sda_line = m_sda & ~sda_pull;

  always #2.5 clk = ~clk;

  eeprom_addr_decode i_eeprom_addr_decode (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .strap_sel(strap_sel), .wp_locked(wp_locked), .sda_pull(sda_pull),
    .hit(hit), .region(region), .rd(rd), .ptr_only(ptr_only));

  typedef struct {
    bit ack; logic [1:0] reg_e; bit rd_e; bit ptr_e; string tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  int hits_seen = 0;
  logic [1:0] reg_seen;
  bit rd_seen, ptr_seen, ack_seen;
  event txn_done;
  bit mon_busy = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; wcyc(HP/2);
    m_scl = 1'b1; wcyc(HP/2);
    m_sda = 1'b0; wcyc(HP/2);
    m_scl = 1'b0; wcyc(HP/2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wcyc(HP/2);
    m_scl = 1'b1; wcyc(HP/2);
    m_sda = 1'b1; wcyc(HP);
  endtask

  task automatic send_bit(bit b);
    m_sda = b;    wcyc(HP/2);
    m_scl = 1'b1; wcyc(HP);
    m_scl = 1'b0; wcyc(HP/2);
  endtask

  task automatic send_bits(logic [7:0] w, int n);
    for (int i = 7; i > 7 - n; i--) send_bit(w[i]);
  endtask

  task automatic ack_clock(string tag);
    m_sda = 1'b1; wcyc(HP/2);
    m_scl = 1'b1; wcyc(HP/2);
    ack_seen = ~sda_line;
    wcyc(HP/2);
    m_scl = 1'b0; wcyc(HP/2);
    chk(sda_pull == 1'b0, tag, "sda released after ninth clock (R7)", sda_pull, 0);
  endtask

  task automatic txn(logic [7:0] w, bit ack, logic [1:0] r, bit p, string tag);
    exp_t e;
    e.ack = ack; e.reg_e = r; e.rd_e = w[0]; e.ptr_e = p; e.tag = tag;
    exp_q.push_back(e);
    send_bits(w, 8);
    ack_clock(tag);
    -> txn_done;
    wcyc(4);
    wait (!mon_busy);
    do_stop();
  endtask

  always @(negedge clk) begin
    if (hit) begin
      hits_seen++;
      reg_seen = region; rd_seen = rd; ptr_seen = ptr_only;
    end
  end

  initial begin
    forever begin
      exp_t e;
      @(txn_done);
      mon_busy = 1;
      e = exp_q.pop_front();
      chk(ack_seen == e.ack, e.tag, "ack on SDA", ack_seen, e.ack);
      chk(hits_seen == int'(e.ack), e.tag, "hit pulses", hits_seen, e.ack);
      if (e.ack && hits_seen == 1) begin
        chk(reg_seen == e.reg_e, e.tag, "region", reg_seen, e.reg_e);
        chk(rd_seen == e.rd_e, e.tag, "rd flag (R10)", rd_seen, e.rd_e);
        chk(ptr_seen == e.ptr_e, e.tag, "ptr_only", ptr_seen, e.ptr_e);
      end
      hits_seen = 0;
      mon_busy = 0;
    end
  end

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    wcyc(5);
    chk(sda_pull == 1'b0, "R9", "sda_pull in reset", sda_pull, 0);
    chk(hit == 1'b0, "R9", "hit in reset", hit, 0);
    rst_n = 1'b1;
    wcyc(10);

    // R1 main array, both directions
    do_start(); txn(8'b1010_101_0, 1, 2'b00, 0, "R1");
    do_start(); txn(8'b1010_101_1, 1, 2'b00, 0, "R1");
    // R7 ack timing: driven after the eighth falling edge, before the ninth rise
    do_start(); send_bits(8'b1010_101_1, 8); wcyc(HP/4);
    chk(sda_pull == 1'b1, "R7", "ack driven after eighth fall", sda_pull, 1);
    exp_q.push_back('{1, 2'b00, 1, 0, "R7"});
    hits_seen = 1; reg_seen = 2'b00; rd_seen = 1; ptr_seen = 0;
    wcyc(HP/4);
    ack_clock("R7"); -> txn_done; wcyc(4); wait (!mon_busy); do_stop();
    // R2 write-protect register
    do_start(); txn(8'b0110_101_0, 1, 2'b01, 0, "R2");
    do_start(); txn(8'b0110_101_1, 0, 2'b00, 0, "R2");
    // R3 locked
    wp_locked = 1'b1;
    do_start(); txn(8'b0110_101_0, 0, 2'b00, 0, "R3");
    do_start(); txn(8'b1010_101_0, 1, 2'b00, 0, "R3");
    wp_locked = 1'b0;
    // R4 identity block
    do_start(); txn(8'b1011_101_1, 1, 2'b10, 0, "R4");
    do_start(); txn(8'b1011_101_0, 1, 2'b10, 1, "R4");
    // R5 strap mismatch in each position
    do_start(); txn(8'b1010_001_0, 0, 2'b00, 0, "R5");
    do_start(); txn(8'b1010_111_1, 0, 2'b00, 0, "R5");
    do_start(); txn(8'b1010_100_0, 0, 2'b00, 0, "R5");
    strap_sel = 3'b010;
    do_start(); txn(8'b1011_010_1, 1, 2'b10, 0, "R5");
    strap_sel = 3'b101;
    // R6 foreign codes
    do_start(); txn(8'b1110_101_0, 0, 2'b00, 0, "R6");
    do_start(); txn(8'b0010_101_1, 0, 2'b00, 0, "R6");
    // R8 repeated START mid-word, then a full word
    do_start(); send_bits(8'b0110_1110, 4);
    do_start(); txn(8'b1010_101_1, 1, 2'b00, 0, "R8");
    // R8 STOP mid-word, then bare clocks without START
    do_start(); send_bits(8'b1010_1010, 3); do_stop();
    m_scl = 1'b0; wcyc(HP);
    txn(8'b1010_101_0, 0, 2'b00, 0, "R8");

    wcyc(20);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule